// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches six external interrupt pins and keeps one request flag per channel. Each pin first passes through a synchronizer. Its synchronized level is then compared with the value it had one cycle earlier. A channel can fire on a single edge, and a per-channel polarity input picks which one. It can also fire on every transition, which is chosen by a bit in an 8-bit configuration register. A flag that has been set stays high until its clear input is pulsed.

Request slots 4 and 5 are each shared between an external pin and a serial-port request pulse. Two select bits in the configuration register decide which of the two sources may set the shared flag. The source that is not selected has no effect on that flag. Priority resolution, vector generation and the serial ports themselves are outside this block.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset the configuration register holds 0x00: every channel is in single-edge mode, and both shared slots take their serial sources. All request outputs are low.
- R2: In single-edge mode with polarity 0, a falling pin transition sets the channel's request. A rising transition does not.
- R3: In single-edge mode with polarity 1, a rising pin transition sets the request. A falling transition does not.
- R4: Configuration bit n (n = 0..5) set to 1 puts channel n in both-edges mode. Every transition then sets the request, whatever the polarity input is.
- R5: A pin level first sampled at rising clock edge A has not yet set the request after edge A+1. The request is high after edge A+2.
- R6: Configuration bit 6 picks the source for slot 4: 0 selects serial request 0, and 1 selects pin 4. The source that is not selected never sets request 4.
- R7: Configuration bit 7 picks the source for slot 5 in the same way: 0 selects serial request 1, and 1 selects pin 5. The source that is not selected never sets request 5.
- R8: A request stays high until its clear input is sampled high. It is low after that edge.
- R9: If a set event and a clear arrive at the same edge, the request stays high.
- R10: Writing the configuration register or changing the polarity inputs while the pins are stable does not set any request.
- R11: A selected serial request pulse sampled at edge A sets the slot's request directly after edge A, with no edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wdata_i | input | 8 | Configuration write data |
| pol_i | input | 6 | Per-channel polarity: 0 selects falling, 1 selects rising |
| pin_i | input | 6 | Asynchronous interrupt pins |
| sio_req_i | input | 2 | Serial request pulses for slots 4 and 5 |
| clr_i | input | 6 | Per-channel request clear |
| req_o | output | 6 | Latched request flags |

## Verification
Each pin result comes two edges after the edge that first samples the new pin level. The bench drives every input on the falling clock edge. It checks at the falling edge after A+1 that the request is still low, and at the falling edge after A+2 that it holds the expected value. Serial pulses, clears and configuration writes act one edge after they are sampled, so those results are read at the next falling edge. Statements that something is ignored are checked by holding the state for several cycles and reading req_o before the next stimulus.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned CH_NUM = 6;
  localparam int unsigned SHARED_NUM = 2;
  localparam int unsigned SHARED_BASE = CH_NUM - SHARED_NUM;

  typedef enum logic {
    SRC_SERIAL = 1'b0,
    SRC_PIN    = 1'b1
  } slot_src_e;

  typedef struct packed {
    logic [SHARED_NUM-1:0] src_sel;
    logic [CH_NUM-1:0]     both_edge;
  } irq_cfg_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge_det.sv
module ext_irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic both_i,
  input  logic pol_i,
  output logic hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  // both-edges ignores polarity so pol=1 stays deterministic
  always_comb begin
    if (both_i)     hit_o = rise | fall;
    else if (pol_i) hit_o = rise;
    else            hit_o = fall;
  end
endmodule

// File: rtl/ext_irq_req_flag.sv
module ext_irq_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_o <= 1'b0;
    else if (set_i) req_o <= 1'b1;   // set beats clear
    else if (clr_i) req_o <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH      = CH_NUM,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [1:0]        sio_req_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] req_o
);
  localparam int unsigned FIRST_SHARED = NUM_CH - SHARED_NUM;

  irq_cfg_t          cfg_q;
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] edge_hit;
  logic [NUM_CH-1:0] slot_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= irq_cfg_t'(cfg_wdata_i);
  end

  ext_irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ext_irq_edge_det i_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pin_sync[c]),
      .both_i(cfg_q.both_edge[c]),
      .pol_i (pol_i[c]),
      .hit_o (edge_hit[c])
    );

    if (c >= FIRST_SHARED) begin : g_shared
      assign slot_set[c] = (cfg_q.src_sel[c-FIRST_SHARED] == SRC_PIN)
                           ? edge_hit[c] : sio_req_i[c-FIRST_SHARED];
    end else begin : g_plain
      assign slot_set[c] = edge_hit[c];
    end

    ext_irq_req_flag i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (slot_set[c]),
      .clr_i (clr_i[c]),
      .req_o (req_o[c])
    );
  end
endmodule

// File: rtl/ext_irq_edge_chk.sv
module ext_irq_edge_chk #(
  parameter int unsigned NUM_CH = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        cfg_i,
  input logic [NUM_CH-1:0] hit_i,
  input logic [1:0]        sio_req_i,
  input logic [NUM_CH-1:0] clr_i,
  input logic [NUM_CH-1:0] set_i,
  input logic [NUM_CH-1:0] req_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[c] && clr_i[c]) |=> req_i[c]);
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !set_i[c]) |=> !req_i[c]);
    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[c] && !set_i[c]) |=> $stable(req_i[c]));
  end

  for (genvar s = 0; s < 2; s++) begin : g_shr
    localparam int unsigned SL = NUM_CH - 2 + s;
    // R6 / R7: unselected source cannot set the shared flag
    assert_pin_mode_ignores_serial_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[6+s] && !hit_i[SL] && !req_i[SL] && !clr_i[SL]) |=> !req_i[SL]);
    assert_serial_mode_ignores_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_i[6+s] && !sio_req_i[s] && !req_i[SL] && !clr_i[SL]) |=> !req_i[SL]);
    assert_serial_direct_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_i[6+s] && sio_req_i[s]) |=> req_i[SL]);
  end
endmodule

bind ext_irq_edge_unit ext_irq_edge_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_i    (cfg_q),
  .hit_i    (edge_hit),
  .sio_req_i(sio_req_i),
  .clr_i    (clr_i),
  .set_i    (slot_set),
  .req_i    (req_o)
);

// File: tb/test_ext_irq_edge_unit.sv
module test_ext_irq_edge_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [5:0] pol = '0;
  logic [5:0] pin = '0;
  logic [1:0] sio = '0;
  logic [5:0] clr = '0;
  logic [5:0] req;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_edge_unit i_ext_irq_edge_unit (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .pol_i(pol), .pin_i(pin), .sio_req_i(sio), .clr_i(clr), .req_o(req)
  );

  // {exp[13], to[12], ch[11:9], pol[8], cfg[7:0]}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h00},  // R2 falling
    {1'b0, 1'b1, 3'd0, 1'b0, 8'h00},  // R2 rising ignored
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h00},  // R3 rising
    {1'b0, 1'b0, 3'd1, 1'b1, 8'h00},  // R3 falling ignored
    {1'b1, 1'b1, 3'd2, 1'b0, 8'h04},  // R4 both, rise
    {1'b1, 1'b0, 3'd2, 1'b0, 8'h04},  // R4 both, fall
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h08},  // R4 both with pol=1
    {1'b0, 1'b0, 3'd4, 1'b0, 8'h00},  // R6 serial selected, pin ignored
    {1'b1, 1'b0, 3'd4, 1'b0, 8'h40},  // R6 pin selected
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h80},  // R7 pin selected
    {1'b0, 1'b1, 3'd5, 1'b1, 8'h00},  // R7 serial selected, pin ignored
    {1'b1, 1'b1, 3'd5, 1'b0, 8'hA0}   // R7 + R4 both on shared slot
  };

  task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: req actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all;
    clr = '1; tick(1); clr = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    check(req, 6'b0, "R1 reset");
    rst_n = 1'b1;
    tick(2);
    check(req, 6'b0, "R1 idle after reset");

    // R1/R11: reset config routes serial sources to slots 4 and 5
    sio = 2'b01; tick(1); sio = '0;
    check(req, 6'b010000, "R11 serial0 sets slot 4 next edge");
    sio = 2'b10; tick(1); sio = '0;
    check(req, 6'b110000, "R1 serial1 routed after reset");
    tick(5);
    check(req, 6'b110000, "R8 request held");
    clr = 6'b010000; tick(1); clr = '0;
    check(req, 6'b100000, "R8 clear lowers next edge");
    // R9 set and clear together
    sio = 2'b01; clr = 6'b010000; tick(1); sio = '0; clr = '0;
    check(req, 6'b110000, "R9 set wins over clear");
    clear_all();

    // table walk
    for (int v = 0; v < NV; v++) begin
      automatic logic [7:0] c  = VEC[v][7:0];
      automatic int         ch = int'(VEC[v][11:9]);
      automatic logic       to = VEC[v][12];
      automatic logic       ex = VEC[v][13];
      write_cfg(c);
      pol[ch] = VEC[v][8];
      pin[ch] = ~to;
      tick(5);
      clear_all();
      tick(1);
      pin[ch] = to;
      tick(2);
      check(req, 6'b0, $sformatf("R5 vec%0d not yet", v));
      tick(1);
      check(req, ex ? (6'b1 << ch) : 6'b0, $sformatf("R5 vec%0d ch%0d", v, ch));
      clear_all();
    end

    // R6/R7: pin mode ignores serial pulses
    write_cfg(8'hC0);
    clear_all();
    sio = 2'b11; tick(1); sio = '0;
    tick(3);
    check(req, 6'b0, "R6 R7 serial ignored in pin mode");

    // R10: config and polarity changes with stable pins
    clear_all();
    tick(4);
    write_cfg(8'hFF);
    pol = ~pol; tick(2);
    write_cfg(8'h00);
    pol = '0; tick(2);
    write_cfg(8'h3F); tick(4);
    check(req, 6'b0, "R10 no spurious request");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule